// File: doc/BRIEF.md
# Game Pad Key Capture Controller

This block sits on a narrow byte-wide register bus. It takes a 16-bit parallel button vector from a game pad and captures it into two read-only byte registers: one holds the low key byte, the other the high key byte. An 8-bit control/status register drives two capture methods.

A timed capture counts down a fixed number of clock cycles and then latches the keys. A stepped capture is advanced by firmware. Firmware arms a phase counter, then toggles a clock bit on successive control writes, and the keys are latched when the counter runs out. When a timed capture completes, the block can raise a level interrupt. The interrupt depends on the captured key pattern and is gated by a mask bit. Writing the mask bit as one also acknowledges the interrupt.

Register addresses are 0 for the low key byte, 1 for the high key byte and 2 for control/status. Address 3 is unused. The timed duration (`READ_CYCLES`, default 10240) and the phase count (`SW_STEPS`, default 32) are parameters.

Top module: `padread_ctrl`

## Requirements
- R1: After reset, both key bytes read 0x00, control/status reads 0x4C, the interrupt is low, no capture is in progress and the phase counter is 0.
- R2: Control/status reads as 0x4C OR'd with these fields: mask in bit 7, phase-reset in bit 5, phase-clock in bit 4, timed-busy in bit 1 and capture-disable in bit 0. Bits 7, 5, 4 and 0 hold the last value written to them.
- R3: A control write with bit 2 set and bit 0 clear starts a timed capture if none is running. Busy then reads 1 for exactly READ_CYCLES cycles after the write edge.
- R4: When a timed capture ends, the low key byte takes keys[7:0] and the high key byte takes keys[15:8].
- R5: When a timed capture ends, the interrupt rises only if the mask is 0, keys[15:4] is nonzero and keys[3:1] is zero.
- R6: The interrupt is a level. It stays high through other accesses until a control write with bit 7 set, which clears it.
- R7: A control write with bit 0 set aborts a running timed capture, so no data is latched, and it blocks a start in the same write.
- R8: A control write with bit 5 set loads the phase counter with SW_STEPS, but only when no timed capture is running.
- R9: On a control write with bit 5 clear and a nonzero phase counter, the counter decrements if the written bit 4 differs from the counter's LSB. When it reaches 0, the keys are latched as in R4. Otherwise the counter holds.
- R10: Starting a timed capture clears the phase counter, which cancels a stepped capture.
- R11: Writes to addresses 0, 1 and 3 have no effect, and address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also times the capture countdown |
| rst_n | input | 1 | Active-low synchronous reset |
| keys | input | 16 | Current button state |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Single-cycle write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with READ_CYCLES=20 and SW_STEPS=4. With these values the exact end of a timed capture can be sampled cycle by cycle, and every phase of a stepped capture can be walked in a handful of writes. This brings the last busy cycle, the final phase step, parity-ignored strobes and held phase-reset strobes within reach. Key patterns in a vector table cover each term of the interrupt condition.

// File: rtl/padread_ctrl.sv
module padread_ctrl #(
  parameter int READ_CYCLES = 10240,
  parameter int SW_STEPS    = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] keys,
  input  logic [1:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        irq
);
  localparam int CW = $clog2(READ_CYCLES + 1);
  localparam int SW = $clog2(SW_STEPS + 1);
  localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTL = 2'd2;

  logic [CW-1:0] busy_cnt, busy_kept, busy_nx;
  logic [SW-1:0] step, step_a, step_nx;
  logic [7:0]    data_lo, data_hi;
  logic          mask, sw_rst, sw_clk, hw_dis;
  logic          ctl_wr, abort, start, hw_done, advance, sw_done, mask_nx, irq_nx, key_ok;

  assign ctl_wr    = wr_en && addr == A_CTL;
  assign abort     = ctl_wr && wdata[0];
  assign busy_kept = abort ? '0 : busy_cnt;
  assign start     = ctl_wr && wdata[2] && !wdata[0] && busy_kept == '0;
  assign hw_done   = busy_cnt == CW'(1) && !abort;
  assign busy_nx   = start ? CW'(READ_CYCLES) : (busy_kept != '0 ? busy_kept - CW'(1) : '0);

  always_comb begin
    step_a = start ? '0 : step;
    if (ctl_wr && wdata[5] && busy_kept == '0 && !start) step_a = SW'(SW_STEPS);
  end
  assign advance = ctl_wr && step_a != '0 && !wdata[5] && (wdata[4] != step_a[0]);
  assign step_nx = advance ? step_a - SW'(1) : step_a;
  assign sw_done = advance && step_a == SW'(1);

  assign mask_nx = ctl_wr ? wdata[7] : mask;
  assign key_ok  = (keys[15:4] != 12'd0) && (keys[3:1] == 3'd0);
  always_comb begin
    irq_nx = irq;
    if (ctl_wr && wdata[7]) irq_nx = 1'b0;
    else if (hw_done && !mask_nx && key_ok) irq_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      step     <= '0;
      data_lo  <= '0;
      data_hi  <= '0;
      mask     <= 1'b0;
      sw_rst   <= 1'b0;
      sw_clk   <= 1'b0;
      hw_dis   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      busy_cnt <= busy_nx;
      step     <= step_nx;
      irq      <= irq_nx;
      mask     <= mask_nx;
      if (ctl_wr) begin
        sw_rst <= wdata[5];
        sw_clk <= wdata[4];
        hw_dis <= wdata[0];
      end
      if (hw_done || sw_done) begin
        data_lo <= keys[7:0];
        data_hi <= keys[15:8];
      end
    end
  end

  always_comb begin
    case (addr)
      A_LO:    rdata = data_lo;
      A_HI:    rdata = data_hi;
      A_CTL:   rdata = 8'h4C | {mask, 1'b0, sw_rst, sw_clk, 2'b00, busy_cnt != '0, hw_dis};
      default: rdata = 8'h00;
    endcase
  end

  assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[2] && !wdata[0] && busy_cnt == '0) |=> (busy_cnt == CW'(READ_CYCLES)));
  assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (busy_cnt == '0));
  assert_mask_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wdata[7]) |=> !irq);
  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(busy_cnt) == CW'(1)));
  assert_step_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(step));
endmodule

// File: tb/padread_ctrl_bench.sv
module padread_ctrl_bench;
  localparam int RC = 20;
  localparam int ST = 4;
  localparam int NV = 7;
  // {keys, mask, expected irq}
  localparam logic [17:0] VEC [NV] = '{
    {16'h0010, 1'b0, 1'b1}, {16'h0012, 1'b0, 1'b0}, {16'h000F, 1'b0, 1'b0},
    {16'h8001, 1'b0, 1'b1}, {16'hFFF0, 1'b1, 1'b0}, {16'h1234, 1'b0, 1'b0},
    {16'hA5F0, 1'b0, 1'b1}};

  logic clk = 0, rst_n = 0, wr_en = 0, irq;
  logic [15:0] keys = 0;
  logic [1:0]  addr = 0;
  logic [7:0]  wdata = 0, rdata, v;
  int checks = 0, errors = 0;

  padread_ctrl #(.READ_CYCLES(RC), .SW_STEPS(ST)) u_padread_ctrl (
    .clk(clk), .rst_n(rst_n), .keys(keys), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic chk_data(input string req, input logic [15:0] exp);
    logic [7:0] lo, hi;
    rd(0, lo); rd(1, hi);
    chk(req, {hi, lo}, exp);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_data("R1 data", 16'h0000);
    rd(2, v); chk("R1 ctl", {8'h0, v}, 16'h004C);
    chk("R1 irq", {15'h0, irq}, 16'h0000);
    rd(3, v); chk("R11 unused addr", {8'h0, v}, 16'h0000);

    // Vector table: timed captures, R4 and R5
    for (int i = 0; i < NV; i++) begin
      wr(2, 8'h80);
      keys = VEC[i][17:2];
      wr(2, VEC[i][1] ? 8'h84 : 8'h04);
      repeat (RC) @(negedge clk);
      chk_data("R4 timed latch", VEC[i][17:2]);
      chk("R5 irq condition", {15'h0, irq}, {15'h0, VEC[i][0]});
    end

    // R6 level holds, then clears
    wr(2, 8'h00); repeat (5) @(negedge clk);
    chk("R6 irq held", {15'h0, irq}, 16'h0001);
    wr(2, 8'h80);
    chk("R6 irq cleared", {15'h0, irq}, 16'h0000);

    // R3 exact busy window and R2 busy bit
    keys = 16'h0C30;
    wr(2, 8'h84);
    rd(2, v); chk("R2 busy readback", {8'h0, v}, 16'h00CE);
    repeat (RC - 1) @(negedge clk);
    rd(2, v); chk("R3 busy on last cycle", {15'h0, v[1]}, 16'h0001);
    chk_data("R3 not yet latched", 16'hA5F0);
    @(negedge clk);
    rd(2, v); chk("R3 busy ended", {15'h0, v[1]}, 16'h0000);
    chk_data("R4 latched", 16'h0C30);

    // R2 field readback
    wr(2, 8'hB1);
    rd(2, v); chk("R2 fields", {8'h0, v}, 16'h00FD);

    // R7 disable blocks start; abort in flight
    wr(2, 8'h05);
    rd(2, v); chk("R7 start blocked", {15'h0, v[1]}, 16'h0000);
    wr(2, 8'h84);
    keys = 16'h7770;
    repeat (3) @(negedge clk);
    wr(2, 8'h81);
    rd(2, v); chk("R7 aborted", {15'h0, v[1]}, 16'h0000);
    repeat (RC + 2) @(negedge clk);
    chk_data("R7 no latch after abort", 16'h0C30);

    // R8/R9 stepped capture, held phase-reset, parity-ignored strobe
    keys = 16'h5A3C;
    wr(2, 8'h80); wr(2, 8'hA0); wr(2, 8'hB0); wr(2, 8'h80);
    wr(2, 8'h90); wr(2, 8'h80); wr(2, 8'h90);
    chk_data("R9 not latched before last phase", 16'h0C30);
    wr(2, 8'h80);
    chk_data("R9 latched at zero", 16'h5A3C);

    // R8 phase-reset ignored while timed busy
    keys = 16'h1110;
    wr(2, 8'h84); wr(2, 8'hA0);
    repeat (RC) @(negedge clk);
    chk_data("R8 timed latch", 16'h1110);
    keys = 16'h2220;
    wr(2, 8'h90); wr(2, 8'h80); wr(2, 8'h90); wr(2, 8'h80);
    chk_data("R8 phase not armed", 16'h1110);

    // R10 timed start cancels stepped capture
    keys = 16'h3330;
    wr(2, 8'hA0); wr(2, 8'h90); wr(2, 8'h80);
    wr(2, 8'h84);
    repeat (RC) @(negedge clk);
    chk_data("R10 timed latch", 16'h3330);
    keys = 16'h4440;
    wr(2, 8'h90); wr(2, 8'h80); wr(2, 8'h90); wr(2, 8'h80);
    chk_data("R10 stepped cancelled", 16'h3330);

    // R11 data writes ignored
    wr(0, 8'hFF); wr(1, 8'hEE); wr(3, 8'hDD);
    chk_data("R11 data unchanged", 16'h3330);
    rd(2, v); chk("R11 ctl unchanged", {8'h0, v}, 16'h00CC);

    // R1 reset again mid-capture
    wr(2, 8'h04);
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk_data("R1 data after reset", 16'h0000);
    rd(2, v); chk("R1 ctl after reset", {8'h0, v}, 16'h004C);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule